// File: doc/BRIEF.md
# Miss and Write Command Arbiter

This block sits between the two first-level caches of a processor tile and the single request port toward the memory network. It chooses one of three requesters. The instruction side raises a miss or an uncached fetch. The data side raises a miss, an uncached load or a store-conditional. The write buffer holds posted stores for one cache line. The block sends the chosen request as a command on a valid/ready port. Each command carries a 3-bit transaction type, an address and a burst length in bytes.

Requesters hold a level request together with its address until the block acknowledges it. The acknowledge pulses in the cycle the last flit of that command is accepted. Miss, uncached and store-conditional commands are a single flit. A write-buffer command sends one flit per word, from the buffer's lowest dirty word index to its highest. A mode parameter sets how the write buffer competes with the two caches' requests.

Top module: `miss_cmd_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, `cmd_valid` and all three acknowledges are low.
- R2: `cmd_type` is 3 for an instruction miss, 2 for an instruction uncached fetch, 1 for a data miss, 0 for a data uncached load and for every write-buffer flit, and 4 for a store-conditional. Bit 0 marks cached, bit 1 marks instruction and bit 2 marks store-conditional. A store-conditional never has bit 0 set. `cmd_write` is high only on write-buffer flits.
- R3: Within one cache the kinds are ordered miss first. On the data side, miss beats uncached and uncached beats store-conditional. On the instruction side, miss beats uncached.
- R4: A miss command has a line-aligned address and `cmd_plen` equal to the line size in bytes. An uncached or store-conditional command has a word-aligned address and `cmd_plen` equal to one word.
- R5: A write-buffer command sends flits for word indices `wb_lo` up to `wb_hi`, both captured at grant. Each flit address is the line base plus index times the word size. Every flit carries `cmd_plen` = (`wb_hi`-`wb_lo`+1) x word size. `cmd_last` is high only on the `wb_hi` flit.
- R6: A flit that is valid but not accepted stays valid with the same address, type and length in the next cycle.
- R7: At most one acknowledge is high at a time. It is high exactly when the last flit of that requester's command is accepted. `cmd_valid` is low in the following cycle.
- R8: MODE 1: a pending data request beats an instruction request, and the write buffer is granted only when neither cache requests.
- R9: MODE 2: a pending instruction request beats a data request, and the write buffer is granted only when neither cache requests.
- R10: MODE 3: when both caches request, the one not served last wins, with the data side first after reset. The write buffer is granted only when neither cache requests.
- R11: MODE 4: after a cache request is served, a pending write buffer goes next. After the write buffer is served, cache requests (data before instruction) go first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_miss_req | input | 1 | Instruction-side miss request (level) |
| ic_unc_req | input | 1 | Instruction-side uncached request (level) |
| ic_addr | input | ADDR_W | Instruction-side byte address |
| dc_miss_req | input | 1 | Data-side miss request (level) |
| dc_unc_req | input | 1 | Data-side uncached load request (level) |
| dc_sc_req | input | 1 | Data-side store-conditional request (level) |
| dc_addr | input | ADDR_W | Data-side byte address |
| wb_req | input | 1 | Write buffer has a line to send (level) |
| wb_line | input | ADDR_W-log2(LINE_WORDS*WORD_BYTES) | Line number of the buffered stores |
| wb_lo | input | log2(LINE_WORDS) | Lowest word index to send |
| wb_hi | input | log2(LINE_WORDS) | Highest word index to send |
| cmd_valid | output | 1 | Command flit valid |
| cmd_ready | input | 1 | Command flit accepted |
| cmd_type | output | 3 | Transaction type |
| cmd_write | output | 1 | Flit is a write-buffer word |
| cmd_addr | output | ADDR_W | Flit byte address |
| cmd_plen | output | log2(LINE_WORDS*WORD_BYTES)+1 | Burst length in bytes |
| cmd_last | output | 1 | Last flit of the command |
| ic_ack | output | 1 | Instruction request done |
| dc_ack | output | 1 | Data request done |
| wb_ack | output | 1 | Write-buffer request done |

## Verification
The bench holds requests that re-arm several times, so order faults show up as a wrong type or address in a flit.

- A static-priority mode with the comparison reversed would send the instruction miss first.
- A round-robin flag that never updates would serve the data side twice in a row.
- The interleaved mode, if it dropped its turn flag, would leave both write-buffer commands until after the misses.

Stalled cycles on the command port expose a design that moves its word counter or address before acceptance. Single-word and full-line write bursts probe counters that stop one word early or late. Combined kinds within one cache probe a wrong miss/uncached/store-conditional order, which would yield type 4 where 0 is due.

// File: rtl/cmdarb_pkg.sv
package cmdarb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IMISS,
      ST_IUNC,
      ST_DMISS,
      ST_DUNC,
      ST_DWRITE,
      ST_DSC
   } arb_state_e;

   typedef enum logic [1:0] {
      GR_NONE,
      GR_I,
      GR_D,
      GR_W
   } grant_e;

   // type bits: [0] cached, [1] instruction, [2] store-conditional
   localparam logic [2:0] TT_DUNC  = 3'd0;
   localparam logic [2:0] TT_DMISS = 3'd1;
   localparam logic [2:0] TT_IUNC  = 3'd2;
   localparam logic [2:0] TT_IMISS = 3'd3;
   localparam logic [2:0] TT_DSC   = 3'd4;

endpackage

// File: rtl/cmdarb_pick.sv
module cmdarb_pick
   import cmdarb_pkg::*;
#(
   parameter int MODE = 3
) (
   input  logic   i_pend,
   input  logic   d_pend,
   input  logic   w_pend,
   input  logic   d_first,
   input  logic   w_turn,
   output grant_e grant
);

   generate
      if (MODE < 1 || MODE > 4) begin : g_bad_mode
         $error("cmdarb_pick: MODE must be 1, 2, 3 or 4");
      end

      if (MODE == 1) begin : g_dstatic
         always_comb begin
            if (d_pend)      grant = GR_D;
            else if (i_pend) grant = GR_I;
            else if (w_pend) grant = GR_W;
            else             grant = GR_NONE;
         end
      end else if (MODE == 2) begin : g_istatic
         always_comb begin
            if (i_pend)      grant = GR_I;
            else if (d_pend) grant = GR_D;
            else if (w_pend) grant = GR_W;
            else             grant = GR_NONE;
         end
      end else if (MODE == 3) begin : g_rrobin
         always_comb begin
            if (d_pend && i_pend) grant = d_first ? GR_D : GR_I;
            else if (d_pend)      grant = GR_D;
            else if (i_pend)      grant = GR_I;
            else if (w_pend)      grant = GR_W;
            else                  grant = GR_NONE;
         end
      end else begin : g_interleave
         always_comb begin
            if (w_turn && w_pend) grant = GR_W;
            else if (d_pend)      grant = GR_D;
            else if (i_pend)      grant = GR_I;
            else if (w_pend)      grant = GR_W;
            else                  grant = GR_NONE;
         end
      end
   endgenerate

   // flags unused in some variants are still part of the common interface
   logic unused_flags;
   assign unused_flags = d_first ^ w_turn;

endmodule

// File: rtl/cmdarb_wseq.sv
module cmdarb_wseq #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] lo,
   input  logic [IDX_W-1:0] hi,
   input  logic             step,
   input  logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         hi_q  <= '0;
      end else if (load) begin
         idx_q <= lo;
         hi_q  <= hi;
      end else if (step && !at_last) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign idx     = idx_q;
   assign at_last = (idx_q == hi_q);

   assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx_q <= hi_q);

   assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step && !at_last) |=> idx_q == $past(idx_q) + 1'b1);

endmodule

// File: rtl/miss_cmd_arbiter.sv
module miss_cmd_arbiter
   import cmdarb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int WORD_BYTES = 4,
   parameter int MODE       = 3
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          ic_miss_req,
   input  logic                                          ic_unc_req,
   input  logic [ADDR_W-1:0]                             ic_addr,
   input  logic                                          dc_miss_req,
   input  logic                                          dc_unc_req,
   input  logic                                          dc_sc_req,
   input  logic [ADDR_W-1:0]                             dc_addr,
   input  logic                                          wb_req,
   input  logic [ADDR_W-$clog2(LINE_WORDS*WORD_BYTES)-1:0] wb_line,
   input  logic [$clog2(LINE_WORDS)-1:0]                 wb_lo,
   input  logic [$clog2(LINE_WORDS)-1:0]                 wb_hi,
   output logic                                          cmd_valid,
   input  logic                                          cmd_ready,
   output logic [2:0]                                    cmd_type,
   output logic                                          cmd_write,
   output logic [ADDR_W-1:0]                             cmd_addr,
   output logic [$clog2(LINE_WORDS*WORD_BYTES):0]        cmd_plen,
   output logic                                          cmd_last,
   output logic                                          ic_ack,
   output logic                                          dc_ack,
   output logic                                          wb_ack
);

   localparam int LINE_BYTES = LINE_WORDS * WORD_BYTES;
   localparam int IDX_W      = $clog2(LINE_WORDS);
   localparam int BYTE_W     = $clog2(WORD_BYTES);
   localparam int OFF_W      = IDX_W + BYTE_W;
   localparam int PLEN_W     = OFF_W + 1;
   localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFF_W;
   localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << BYTE_W;
   localparam logic [PLEN_W-1:0] PLEN_LINE = PLEN_W'(LINE_BYTES);
   localparam logic [PLEN_W-1:0] PLEN_WORD = PLEN_W'(WORD_BYTES);

   generate
      if (LINE_WORDS < 2 || (1 << IDX_W) != LINE_WORDS) begin : g_bad_line
         $error("miss_cmd_arbiter: LINE_WORDS must be a power of two, at least 2");
      end
      if (WORD_BYTES < 1 || (1 << BYTE_W) != WORD_BYTES) begin : g_bad_word
         $error("miss_cmd_arbiter: WORD_BYTES must be a power of two");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("miss_cmd_arbiter: ADDR_W too small for the line size");
      end
   endgenerate

   arb_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PLEN_W-1:0] plen_q;
   logic              d_first_q;
   logic              w_turn_q;

   logic              i_pend, d_pend;
   grant_e            grant;
   logic              fire, done;
   logic              w_load, w_step, w_busy, w_at_last;
   logic [IDX_W-1:0]  w_idx;
   logic [IDX_W:0]    w_span;

   assign i_pend = ic_miss_req | ic_unc_req;
   assign d_pend = dc_miss_req | dc_unc_req | dc_sc_req;

   cmdarb_pick #(.MODE(MODE)) u_pick (
      .i_pend  (i_pend),
      .d_pend  (d_pend),
      .w_pend  (wb_req),
      .d_first (d_first_q),
      .w_turn  (w_turn_q),
      .grant   (grant)
   );

   assign w_load = (state_q == ST_IDLE) && (grant == GR_W);
   assign w_busy = (state_q == ST_DWRITE);
   assign w_step = w_busy && fire;

   cmdarb_wseq #(.IDX_W(IDX_W)) u_wseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (w_load),
      .lo      (wb_lo),
      .hi      (wb_hi),
      .step    (w_step),
      .busy    (w_busy),
      .idx     (w_idx),
      .at_last (w_at_last)
   );

   assign w_span = {1'b0, wb_hi} - {1'b0, wb_lo} + (IDX_W+1)'(1);

   assign cmd_valid = (state_q != ST_IDLE);
   assign fire      = cmd_valid && cmd_ready;
   assign cmd_last  = w_busy ? w_at_last : 1'b1;
   assign done      = fire && cmd_last;
   assign cmd_write = w_busy;
   assign cmd_plen  = plen_q;
   assign cmd_addr  = w_busy ? {addr_q[ADDR_W-1:OFF_W], w_idx, BYTE_W'(0)} : addr_q;

   always_comb begin
      case (state_q)
         ST_IMISS: cmd_type = TT_IMISS;
         ST_IUNC:  cmd_type = TT_IUNC;
         ST_DMISS: cmd_type = TT_DMISS;
         ST_DSC:   cmd_type = TT_DSC;
         default:  cmd_type = TT_DUNC;
      endcase
   end

   assign ic_ack = done && (state_q == ST_IMISS || state_q == ST_IUNC);
   assign dc_ack = done && (state_q == ST_DMISS || state_q == ST_DUNC || state_q == ST_DSC);
   assign wb_ack = done && w_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         plen_q    <= '0;
         d_first_q <= 1'b1;
         w_turn_q  <= 1'b0;
      end else if (state_q == ST_IDLE) begin
         case (grant)
            GR_I: begin
               state_q <= ic_miss_req ? ST_IMISS : ST_IUNC;
               addr_q  <= ic_addr & (ic_miss_req ? LINE_MASK : WORD_MASK);
               plen_q  <= ic_miss_req ? PLEN_LINE : PLEN_WORD;
            end
            GR_D: begin
               if (dc_miss_req)     state_q <= ST_DMISS;
               else if (dc_unc_req) state_q <= ST_DUNC;
               else                 state_q <= ST_DSC;
               addr_q <= dc_addr & (dc_miss_req ? LINE_MASK : WORD_MASK);
               plen_q <= dc_miss_req ? PLEN_LINE : PLEN_WORD;
            end
            GR_W: begin
               state_q <= ST_DWRITE;
               addr_q  <= {wb_line, OFF_W'(0)};
               plen_q  <= {w_span, BYTE_W'(0)};
            end
            default: state_q <= ST_IDLE;
         endcase
      end else if (done) begin
         state_q <= ST_IDLE;
         if (ic_ack) begin
            d_first_q <= 1'b1;
            w_turn_q  <= 1'b1;
         end else if (dc_ack) begin
            d_first_q <= 1'b0;
            w_turn_q  <= 1'b1;
         end else begin
            w_turn_q  <= 1'b0;
         end
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !cmd_valid || $past(rst_n) == 1'b1);

   assert_sc_uncached_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type[2]) |-> (!cmd_type[0] && !cmd_type[1] && !cmd_write));

   assert_miss_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type[0]) |-> (cmd_plen == PLEN_LINE && cmd_addr[OFF_W-1:0] == '0));

   assert_write_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && cmd_ready && !cmd_last) |=>
      (cmd_valid && cmd_write && cmd_addr == $past(cmd_addr) + ADDR_W'(WORD_BYTES)));

   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_type) && $stable(cmd_plen)));

   assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ic_ack, dc_ack, wb_ack}));

   assert_ack_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_ack || dc_ack || wb_ack) |=> !cmd_valid);

   generate
      if (MODE != 4) begin : g_wb_last_chk
         assert_wb_yields_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_IDLE && (i_pend || d_pend)) |=> !cmd_write);
      end
   endgenerate

endmodule

// File: tb/sim_miss_cmd_arbiter.sv
`timescale 1ns/1ps
module sim_miss_cmd_arbiter;

   localparam int NM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        imr [NM], iur [NM], dmr [NM], dur [NM], dsr [NM], wr [NM], rdy [NM];
   logic [31:0] ia [NM], da [NM];
   logic [26:0] wl [NM];
   logic [2:0]  wlo [NM], whi [NM];
   logic        cv [NM], cw [NM], cl [NM], ik [NM], dk [NM], wk [NM];
   logic [2:0]  ct [NM];
   logic [31:0] ca [NM];
   logic [5:0]  cp [NM];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   for (genvar k = 0; k < NM; k++) begin : g_m
      miss_cmd_arbiter #(.ADDR_W(32), .LINE_WORDS(8), .WORD_BYTES(4), .MODE(k+1)) u0 (
         .clk(clk), .rst_n(rst_n),
         .ic_miss_req(imr[k]), .ic_unc_req(iur[k]), .ic_addr(ia[k]),
         .dc_miss_req(dmr[k]), .dc_unc_req(dur[k]), .dc_sc_req(dsr[k]), .dc_addr(da[k]),
         .wb_req(wr[k]), .wb_line(wl[k]), .wb_lo(wlo[k]), .wb_hi(whi[k]),
         .cmd_valid(cv[k]), .cmd_ready(rdy[k]), .cmd_type(ct[k]), .cmd_write(cw[k]),
         .cmd_addr(ca[k]), .cmd_plen(cp[k]), .cmd_last(cl[k]),
         .ic_ack(ik[k]), .dc_ack(dk[k]), .wb_ack(wk[k]));
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic do_reset(input int m);
      rst_n = 1'b0;
      for (int k = 0; k < NM; k++) begin
         imr[k] = 0; iur[k] = 0; dmr[k] = 0; dur[k] = 0; dsr[k] = 0; wr[k] = 0; rdy[k] = 0;
         ia[k] = '0; da[k] = '0; wl[k] = '0; wlo[k] = '0; whi[k] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(!cv[m] && !ik[m] && !dk[m] && !wk[m], "R1 quiet in reset",
          {cv[m], ik[m], dk[m], wk[m]}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!cv[m], "R1 quiet after reset without requests", cv[m], 0);
   endtask

   // m: instance (MODE m+1); imask {unc,miss}; dmask {sc,unc,miss}
   task automatic run(input int m, input int ni, input int nd, input int nw,
                      input logic [1:0] imask, input logic [2:0] dmask,
                      input logic [2:0] lo, input logic [2:0] hi,
                      input bit stall, input string order, input string tag);
      int ci, cdn, cwn, pos, wi;
      bit gap, held;
      logic [31:0] haddr, ea;
      logic [2:0] et;
      logic [5:0] ep;
      logic ew, el;
      byte who;
      do_reset(m);
      ia[m] = 32'h1000_0A4E;
      da[m] = 32'h2000_0B3A;
      wl[m] = 27'h0123456;
      wlo[m] = lo;
      whi[m] = hi;
      ci = ni; cdn = nd; cwn = nw;
      imr[m] = (ci > 0) && imask[0];
      iur[m] = (ci > 0) && imask[1];
      dmr[m] = (cdn > 0) && dmask[0];
      dur[m] = (cdn > 0) && dmask[1];
      dsr[m] = (cdn > 0) && dmask[2];
      wr[m]  = (cwn > 0);
      pos = 0; wi = int'(lo); gap = 0; held = 0; haddr = '0;
      for (int cyc = 0; cyc < 3000 && pos < order.len(); cyc++) begin
         @(negedge clk);
         rdy[m] = stall ? ((cyc % 3) != 1) : 1'b1;
         #1;
         if (gap) chk(!cv[m], {tag, " R7 idle cycle after ack"}, cv[m], 0);
         gap = 0;
         if (held) chk(cv[m] && ca[m] == haddr, {tag, " R6 stalled flit held"}, ca[m], haddr);
         held = 0;
         if (cv[m]) begin
            who = order[pos];
            if (who == "I") begin
               et = imask[0] ? 3'd3 : 3'd2;
               ea = imask[0] ? (ia[m] & 32'hFFFF_FFE0) : (ia[m] & 32'hFFFF_FFFC);
               ep = imask[0] ? 6'd32 : 6'd4;
               ew = 0; el = 1;
            end else if (who == "D") begin
               et = dmask[0] ? 3'd1 : (dmask[1] ? 3'd0 : 3'd4);
               ea = dmask[0] ? (da[m] & 32'hFFFF_FFE0) : (da[m] & 32'hFFFF_FFFC);
               ep = dmask[0] ? 6'd32 : 6'd4;
               ew = 0; el = 1;
            end else begin
               et = 3'd0;
               ea = {wl[m], 5'd0} + 32'(wi * 4);
               ep = 6'((int'(hi) - int'(lo) + 1) * 4);
               ew = 1; el = (wi == int'(hi));
            end
            chk(ct[m] == et, {tag, " order/type (R2, R3)"}, ct[m], et);
            chk(cw[m] == ew, {tag, " R2 write flag"}, cw[m], ew);
            chk(ca[m] == ea, {tag, ew ? " R5 write flit address" : " R4 address"}, ca[m], ea);
            chk(cp[m] == ep, {tag, ew ? " R5 write length" : " R4 length"}, cp[m], ep);
            chk(cl[m] == el, {tag, " R5 last flag"}, cl[m], el);
            chk({ik[m], dk[m], wk[m]} ==
                {(who == "I") && rdy[m] && el, (who == "D") && rdy[m] && el,
                 (who == "W") && rdy[m] && el},
                {tag, " R7 acknowledge"}, {ik[m], dk[m], wk[m]},
                {(who == "I") && rdy[m] && el, (who == "D") && rdy[m] && el,
                 (who == "W") && rdy[m] && el});
            if (rdy[m]) begin
               if (el) begin
                  pos++;
                  gap = 1;
                  wi = int'(lo);
                  if (who == "I") begin
                     ci--;
                     if (ci == 0) begin imr[m] = 0; iur[m] = 0; end
                  end else if (who == "D") begin
                     cdn--;
                     if (cdn == 0) begin dmr[m] = 0; dur[m] = 0; dsr[m] = 0; end
                  end else begin
                     cwn--;
                     if (cwn == 0) wr[m] = 0;
                  end
               end else begin
                  wi++;
               end
            end else begin
               held = 1;
               haddr = ca[m];
            end
         end
      end
      chk(pos == order.len(), {tag, " all commands completed in time"}, pos, order.len());
      @(negedge clk);
      #1;
      chk(!cv[m], {tag, " port idle once requests served"}, cv[m], 0);
      rdy[m] = 0;
   endtask

   initial begin
      for (int k = 0; k < NM; k++) do_reset(k);
      // MODE 1: data first, then instruction, write buffer last
      run(0, 2, 2, 1, 2'b01, 3'b001, 3'd2, 3'd5, 1'b0, "DDIIW", "R8");
      // MODE 2: instruction first
      run(1, 2, 2, 1, 2'b01, 3'b001, 3'd1, 3'd3, 1'b1, "IIDDW", "R9");
      // MODE 3: alternate, data first after reset
      run(2, 2, 2, 1, 2'b01, 3'b001, 3'd0, 3'd7, 1'b1, "DIDIW", "R10");
      // MODE 4: write buffer interleaved after each cache request
      run(3, 1, 2, 2, 2'b01, 3'b001, 3'd2, 3'd5, 1'b0, "DWDWI", "R11");
      // kind order inside one cache
      run(2, 1, 1, 0, 2'b11, 3'b110, 3'd0, 3'd0, 1'b0, "DI", "R3");
      run(2, 1, 1, 0, 2'b11, 3'b111, 3'd0, 3'd0, 1'b1, "DI", "R3");
      // store-conditional and instruction uncached encodings
      run(2, 1, 1, 0, 2'b10, 3'b100, 3'd0, 3'd0, 1'b1, "DI", "R2");
      // single-word and full-line write bursts
      run(0, 0, 0, 1, 2'b00, 3'b000, 3'd7, 3'd7, 1'b1, "W", "R5");
      run(3, 0, 0, 2, 2'b00, 3'b000, 3'd0, 3'd7, 1'b1, "WW", "R5");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired (R7 progress) actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule